// File: doc/BRIEF.md
# Vectored Interrupt Controller with Sense Select

The controller collects sixteen active-low interrupt sources and presents them to a processor as one interrupt request line plus four 32-bit registers reached through a simple synchronous register port. Sources are numbered 0 to 15 and placed MSB-first in each register, so source n occupies bit 31−n. Even-numbered sources model external pins whose sense is chosen per source: level or falling edge. Odd-numbered sources model on-chip requesters and always act on level, whatever their sense bit holds.

Level-sensed sources show as pending while their synchronized input is low. Edge-sensed sources latch a sticky pending bit on each falling edge seen after a two-flop synchronizer, and software removes it by writing one to that bit of the pending register. The enable mask gates pending sources onto the request line. A priority encoder picks the lowest-numbered enabled pending source and places its number in the top six bits of the vector register. Code 15 means nothing is pending, and it is also the code of source 15 itself. Software reads the vector, shifts it right by 26, and dispatches.

Register selects on `reg_addr`: 0 pending (write one to clear), 1 enable mask, 2 sense select (1 = falling edge), 3 vector (read only). Read data appears on `reg_rdata` one clock after `reg_rd` and holds until the next read.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset the mask and sense registers read 0, the pending register reads 0 with all inputs high, the vector reads 15 in bits 31:26, and `cpu_irq` is low.
- R2: Source n maps to bit 31−n of the mask, pending and sense registers. Bits 15:0 of these registers read 0, and a full mask or sense write reads back with bits 31:16 intact.
- R3: `cpu_irq` is high exactly when some source is both pending and enabled (mask bit 1). A mask bit of 0 keeps its source off the line and out of the vector.
- R4: A level-sensed source reads pending while its input is held low and clears once the input returns high.
- R5: Writing 1 to the pending bit of a level-sensed source whose input is still low leaves that bit reading 1.
- R6: With its sense bit 1, an even source sets a pending bit on a falling edge of its input, and the bit stays set after the input goes high again.
- R7: Writing 1 to a sticky pending bit clears it. Writing 0 leaves it set.
- R8: An odd source with its sense bit set still acts on level: a low pulse leaves no pending bit once the input is high again.
- R9: The vector register holds the lowest-numbered enabled pending source in bits 31:26, and its bits 25:0 read 0.
- R10: With no enabled source pending, the vector register reads code 15 in bits 31:26.
- R11: A falling edge detected in the same cycle as a clear write to that bit leaves the pending bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_in_n | input | 16 | Active-low interrupt sources, bit n is source n |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select: 0 pending, 1 mask, 2 sense, 3 vector |
| reg_wdata | input | 32 | Write data, MSB-first source bits |
| reg_rdata | output | 32 | Read data, valid the cycle after a read |
| cpu_irq | output | 1 | Interrupt request to the processor |

## Verification
A wrong bit in the edge latch or the mask register shows on `cpu_irq` in the same cycle and on the next vector read. A lost clear leaves the request line high. A spurious latch reports a source number that no input asked for. Level pending follows the input with two cycles of synchronizer delay, and edge pending follows it with three. The bench sweeps every single source and every pair of sources against these delays, so an error in priority order or bit placement shows on the first read after the inputs settle.

// File: rtl/virq_pkg.sv
package virq_pkg;
  localparam int REG_W  = 32;
  localparam int CODE_W = 6;

  typedef enum logic [1:0] {
    SEL_PEND  = 2'd0,
    SEL_MASK  = 2'd1,
    SEL_SENSE = 2'd2,
    SEL_VEC   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/virq_sync.sv
module virq_sync #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw_n,
  output logic [N-1:0] sync_n,
  output logic [N-1:0] prev_n
);
  logic [N-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      sync_q <= '1;
      prev_q <= '1;
    end else begin
      meta_q <= raw_n;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign sync_n = sync_q;
  assign prev_n = prev_q;
endmodule

// File: rtl/virq_pend.sv
module virq_pend #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sync_n,
  input  logic [N-1:0] prev_n,
  input  logic [N-1:0] sense_sel,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);
  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_src
      if (i % 2 == 0) begin : g_ext
        logic latch_q, latch_d, fall;
        assign fall = prev_n[i] & ~sync_n[i];
        always_comb begin
          if (!sense_sel[i]) latch_d = 1'b0;
          else               latch_d = fall | (latch_q & ~clr[i]);
        end
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) latch_q <= 1'b0;
          else        latch_q <= latch_d;
        end
        assign pend[i] = sense_sel[i] ? latch_q : ~sync_n[i];
      end else begin : g_int
        logic unused_int;
        assign unused_int = sense_sel[i] ^ prev_n[i] ^ clr[i];
        assign pend[i]    = ~sync_n[i];
      end
    end
  endgenerate
endmodule

// File: rtl/virq_prio.sv
module virq_prio #(
  parameter int N      = 16,
  parameter int CODE_W = 6,
  parameter int IDLE   = 15
) (
  input  logic [N-1:0]      active,
  output logic [CODE_W-1:0] code
);
  always_comb begin
    code = CODE_W'(IDLE);
    for (int i = N - 1; i >= 0; i--) begin
      if (active[i]) code = CODE_W'(i);
    end
  end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import virq_pkg::*;
#(
  parameter int NSRC = 16,
  parameter int IDLE = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  irq_in_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [1:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             cpu_irq
);
  localparam int PAD_W = REG_W - CODE_W;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  // write data in source order
  logic [NSRC-1:0] wsrc;
  genvar k;
  generate
    for (k = 0; k < NSRC; k++) begin : g_wmap
      assign wsrc[k] = reg_wdata[REG_W-1-k];
    end
    if (NSRC < REG_W) begin : g_unused
      logic unused_wlow;
      assign unused_wlow = ^reg_wdata[REG_W-NSRC-1:0];
    end
  endgenerate

  logic wr_pend, wr_mask, wr_sense;
  assign wr_pend  = reg_wr && (reg_addr == SEL_PEND);
  assign wr_mask  = reg_wr && (reg_addr == SEL_MASK);
  assign wr_sense = reg_wr && (reg_addr == SEL_SENSE);

  // configuration registers
  logic [NSRC-1:0] mask_q, mask_d, sense_q, sense_d;
  always_comb begin
    mask_d  = wr_mask  ? wsrc : mask_q;
    sense_d = wr_sense ? wsrc : sense_q;
  end
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      mask_q  <= '0;
      sense_q <= '0;
    end else begin
      mask_q  <= mask_d;
      sense_q <= sense_d;
    end
  end

  // sources
  logic [NSRC-1:0] sync_n, prev_n, clr, pend, active;
  assign clr = wr_pend ? wsrc : '0;

  virq_sync #(.N(NSRC)) u_sync (
    .clk(clk), .rst_n(rst_i), .raw_n(irq_in_n),
    .sync_n(sync_n), .prev_n(prev_n)
  );

  virq_pend #(.N(NSRC)) u_pend (
    .clk(clk), .rst_n(rst_i), .sync_n(sync_n), .prev_n(prev_n),
    .sense_sel(sense_q), .clr(clr), .pend(pend)
  );

  assign active  = pend & mask_q;
  assign cpu_irq = |active;

  logic [CODE_W-1:0] code;
  virq_prio #(.N(NSRC), .CODE_W(CODE_W), .IDLE(IDLE)) u_prio (
    .active(active), .code(code)
  );

  // read path, MSB-first words
  logic [REG_W-1:0] pend_w, mask_w, sense_w, vec_w;
  generate
    for (k = 0; k < REG_W; k++) begin : g_rmap
      if (k < NSRC) begin : g_src
        assign pend_w[REG_W-1-k]  = pend[k];
        assign mask_w[REG_W-1-k]  = mask_q[k];
        assign sense_w[REG_W-1-k] = sense_q[k];
      end else begin : g_pad
        assign pend_w[REG_W-1-k]  = 1'b0;
        assign mask_w[REG_W-1-k]  = 1'b0;
        assign sense_w[REG_W-1-k] = 1'b0;
      end
    end
  endgenerate
  assign vec_w = {code, {PAD_W{1'b0}}};

  logic [REG_W-1:0] rdata_q, rdata_d;
  always_comb begin
    rdata_d = rdata_q;
    if (reg_rd) begin
      unique case (reg_addr)
        SEL_PEND:  rdata_d = pend_w;
        SEL_MASK:  rdata_d = mask_w;
        SEL_SENSE: rdata_d = sense_w;
        default:   rdata_d = vec_w;
      endcase
    end
  end
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end
  assign reg_rdata = rdata_q;
endmodule

// File: rtl/virq_chk.sv
module virq_chk #(
  parameter int NSRC = 16,
  parameter int IDLE = 15
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_rd,
  input logic [1:0]      reg_addr,
  input logic [31:0]     reg_rdata,
  input logic            cpu_irq,
  input logic [NSRC-1:0] mask_q
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !cpu_irq);

  // R9
  vec_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 2'd3) |=> (reg_rdata[25:0] == 26'd0));

  // R10
  vec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 2'd3 && !cpu_irq) |=> (reg_rdata[31:26] == 6'(IDLE)));

  // R3
  vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 2'd3 && cpu_irq) |=> (reg_rdata[31:26] < 6'(NSRC)));

  // R3
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !cpu_irq);

  // R2
  mask_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 2'd1) |=> (reg_rdata[15:0] == 16'd0));
endmodule

bind vec_irq_ctrl virq_chk #(.NSRC(NSRC), .IDLE(IDLE)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .cpu_irq(cpu_irq), .mask_q(mask_q)
);

// File: tb/sim_vec_irq_ctrl.sv
`timescale 1ns/1ps
module sim_vec_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] irq_in_n;
  logic        reg_wr, reg_rd;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        cpu_irq;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  vec_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .irq_in_n(irq_in_n), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cpu_irq(cpu_irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [31:0] sbit(input int n);
    return 32'h8000_0000 >> n;
  endfunction

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; irq_in_n = '1; reg_wr = 1'b0; reg_rd = 1'b0;
    reg_addr = 2'd0; reg_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    settle();

    // R1 reset state
    rd(2'd1, d); check("R1 mask", d, 32'h0);
    rd(2'd2, d); check("R1 sense", d, 32'h0);
    rd(2'd0, d); check("R1 pending", d, 32'h0);
    rd(2'd3, d); check("R1 vector", d, 32'd15 << 26);
    check("R1 cpu_irq", {31'd0, cpu_irq}, 32'd0);

    // R2 readback with padding bits dropped
    wr(2'd1, 32'hFFFF_FFFF); rd(2'd1, d); check("R2 mask readback", d, 32'hFFFF_0000);
    wr(2'd2, 32'hA5C3_1234); rd(2'd2, d); check("R2 sense readback", d, 32'hA5C3_0000);
    wr(2'd2, 32'h0);

    // R4 R3 R9 R10 single-source sweep, level sense
    for (int n = 0; n < 16; n++) begin
      irq_in_n = ~(16'd1 << n);
      settle();
      rd(2'd0, d); check("R4 R2 level pending", d, sbit(n));
      rd(2'd3, d); check("R9 vector", d, 32'(n) << 26);
      check("R3 irq on", {31'd0, cpu_irq}, 32'd1);
      wr(2'd1, 32'hFFFF_0000 & ~sbit(n));
      check("R3 irq masked", {31'd0, cpu_irq}, 32'd0);
      rd(2'd3, d); check("R10 masked vector", d, 32'd15 << 26);
      wr(2'd1, 32'hFFFF_0000);
      irq_in_n = '1;
      settle();
      rd(2'd0, d); check("R4 level released", d, 32'h0);
    end

    // R9 priority over every pair
    for (int i = 0; i < 16; i++) begin
      for (int j = i + 1; j < 16; j++) begin
        irq_in_n = ~((16'd1 << i) | (16'd1 << j));
        settle();
        rd(2'd3, d); check("R9 pair priority", d, 32'(i) << 26);
      end
    end
    irq_in_n = '1;
    settle();
    rd(2'd3, d); check("R10 idle vector", d, 32'd15 << 26);

    // R5 level clear has no lasting effect
    irq_in_n = ~16'h0008;
    settle();
    wr(2'd0, sbit(3));
    rd(2'd0, d); check("R5 level clear ignored", d, sbit(3));
    irq_in_n = '1;
    settle();

    // R6 R8 edge sense on all sources
    wr(2'd2, 32'hFFFF_0000);
    for (int n = 0; n < 16; n++) begin
      irq_in_n = ~(16'd1 << n);
      settle();
      irq_in_n = '1;
      settle();
      rd(2'd0, d);
      if (n % 2 == 0) check("R6 sticky edge", d & sbit(n), sbit(n));
      else            check("R8 odd stays level", d & sbit(n), 32'h0);
    end
    rd(2'd0, d); check("R6 even sticky set", d, 32'hAAAA_0000);
    check("R3 irq from sticky", {31'd0, cpu_irq}, 32'd1);

    // R7 write-one-to-clear
    wr(2'd0, 32'h0);
    rd(2'd0, d); check("R7 zero write keeps", d, 32'hAAAA_0000);
    wr(2'd0, sbit(4));
    rd(2'd0, d); check("R7 single clear", d, 32'hA2AA_0000);
    rd(2'd3, d); check("R9 vector after clear", d, 32'd0);
    wr(2'd0, 32'hFFFF_0000);
    rd(2'd0, d); check("R7 all cleared", d, 32'h0);
    check("R7 irq low", {31'd0, cpu_irq}, 32'd0);

    // R11 edge wins over a clear in the same cycle
    irq_in_n = ~16'h0001; settle(); irq_in_n = '1; settle();
    @(negedge clk);
    irq_in_n = ~16'h0001;
    @(negedge clk);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = sbit(0);
    @(negedge clk);
    reg_wr = 1'b0;
    irq_in_n = '1;
    settle();
    rd(2'd0, d); check("R11 edge beats clear", d, sbit(0));
    wr(2'd0, sbit(0));
    rd(2'd0, d); check("R7 clear after race", d, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule